// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a memory-mapped watchdog. A down-counter is loaded with a programmable start value. While the counter is enabled, it counts once per clock. When it reaches zero it raises an interrupt and starts again from the start value. If software has not cleared that interrupt by the next time the counter reaches zero, and the reset path is enabled, the block asserts a reset request. The request stays asserted until the block itself is reset.

Software reaches the block over a simple two-phase register bus. The bus has 32-bit data and a 12-bit byte offset, of which only the word index is decoded. A key register guards every other writable register. Until the key value is written, writes to the other registers are dropped. Any other value written to the key register closes the gate again.

A test mode bypasses the counter logic and drives the two outputs directly from a test register. Fixed identification words can be read at the top of the map.

The bus carries no data stream, so it has no valid/ready pair and never stalls. A write takes effect on the clock edge of its access phase. Read data is driven combinationally during the access phase.

Top module: `kwdt_top`

## Requirements
- R1: The key register sits at offset 0xC00. Writing 0x1ACCE551 to it unlocks the block, and writing any other value locks it. Reading it returns 1 when locked and 0 when unlocked. The block comes out of reset locked.
- R2: While the block is locked, writes to the start value, control, interrupt-clear, test-control and test-output registers have no effect.
- R3: An unlocked write to the start value register at 0x000 updates that register, which reads back at 0x000, and loads the counter at once. The counter reads back at 0x004. After reset both read 0xFFFFFFFF.
- R4: Control register 0x008 uses bit 0 as the interrupt and count enable and bit 1 as the reset enable. While bit 0 is clear, the counter holds its value.
- R5: With start value L and the counter enabled, the interrupt output rises L+1 clock edges after the counter last held L. The counter then reloads L.
- R6: If the interrupt is still pending when the counter next reaches zero and the reset enable is set, the reset output asserts and stays asserted until the block reset.
- R7: An unlocked write of any value to offset 0x00C clears the pending interrupt and reloads the counter from the start value.
- R8: Offset 0x010 returns the pending interrupt in bit 0. Offset 0x014 returns that bit ANDed with control bit 0. The interrupt output equals the 0x014 bit outside test mode.
- R9: When bit 0 of the test-control register at 0xF00 is set, the interrupt output equals bit 0 of the test-output register at 0xF04 and the reset output equals its bit 1.
- R10: Offsets 0xFE0 to 0xFFC return fixed identification bytes in bits 7:0: 0x4B, 0x57, 0x10, 0x00, 0xA5, 0x3C, 0x96, 0x0F in rising offset order. Reserved offsets read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus select |
| bus_enable | input | 1 | Access phase of a transfer |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte offset; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access phase |
| wdog_irq | output | 1 | Interrupt output |
| wdog_rst | output | 1 | Reset request output |

## Verification
Every write takes effect on the clock edge that ends its access phase. The bench's write task returns half a cycle after that edge, so register read-backs and output levels are checked straight away. Counter-driven results are timed from the same edge. The interrupt is checked low after L edges and high after L+1 edges. The reset output is checked the same way over the next L+1 edges. Read data is combinational, so it is sampled shortly after the access phase begins. The counter value is compared only while counting is stopped.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int WIDX_W = ADDR_W - 2;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  // word indices (byte offset >> 2)
  localparam logic [WIDX_W-1:0] W_LOAD  = 10'h000;
  localparam logic [WIDX_W-1:0] W_VALUE = 10'h001;
  localparam logic [WIDX_W-1:0] W_CTRL  = 10'h002;
  localparam logic [WIDX_W-1:0] W_CLR   = 10'h003;
  localparam logic [WIDX_W-1:0] W_RAW   = 10'h004;
  localparam logic [WIDX_W-1:0] W_MASK  = 10'h005;
  localparam logic [WIDX_W-1:0] W_LOCK  = 10'h300;
  localparam logic [WIDX_W-1:0] W_TCTRL = 10'h3C0;
  localparam logic [WIDX_W-1:0] W_TOUT  = 10'h3C1;
  // identification window: byte offsets 0xFE0..0xFFC share addr[11:5]
  localparam logic [6:0] ID_WINDOW = 7'h7F;

  typedef struct packed {
    logic int_en;
    logic rst_en;
  } ctrl_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h4B;
      3'd1:    return 8'h57;
      3'd2:    return 8'h10;
      3'd3:    return 8'h00;
      3'd4:    return 8'hA5;
      3'd5:    return 8'h3C;
      3'd6:    return 8'h96;
      default: return 8'h0F;
    endcase
  endfunction
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              raw_irq,
  output logic [CNT_W-1:0]  load_val,
  output ctrl_t             ctrl,
  output logic              test_en,
  output logic [1:0]        test_out,
  output logic              load_wr,
  output logic              clr_wr,
  output logic [DATA_W-1:0] rdata
);
  logic              locked;
  logic              wr_ok;
  logic [WIDX_W-1:0] widx;

  assign widx    = addr[ADDR_W-1:2];
  assign wr_ok   = wr_en && !locked;
  assign load_wr = wr_ok && (widx == W_LOAD);
  assign clr_wr  = wr_ok && (widx == W_CLR);

  // key gate: always writable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        locked <= 1'b1;
    else if (wr_en && widx == W_LOCK)  locked <= (wdata != UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_val <= LOAD_RST;
      ctrl     <= '0;
      test_en  <= 1'b0;
      test_out <= 2'b00;
    end else if (wr_ok) begin
      case (widx)
        W_LOAD:  load_val <= wdata[CNT_W-1:0];
        W_CTRL:  ctrl     <= '{int_en: wdata[0], rst_en: wdata[1]};
        W_TCTRL: test_en  <= wdata[0];
        W_TOUT:  test_out <= wdata[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (widx[WIDX_W-1:3] == ID_WINDOW) begin
        rdata = {24'h0, id_byte(widx[2:0])};
      end else begin
        case (widx)
          W_LOAD:  rdata = DATA_W'(load_val);
          W_VALUE: rdata = DATA_W'(cnt);
          W_CTRL:  rdata = {30'h0, ctrl.rst_en, ctrl.int_en};
          W_RAW:   rdata = {31'h0, raw_irq};
          W_MASK:  rdata = {31'h0, raw_irq & ctrl.int_en};
          W_LOCK:  rdata = {31'h0, locked};
          W_TCTRL: rdata = {31'h0, test_en};
          default: rdata = '0;
        endcase
      end
    end
  end

  // R1: the key value opens the gate on the following cycle
  p_key_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && widx == W_LOCK && wdata == UNLOCK_KEY) |=> !locked)
    else $error("p_key_opens_r1");

  // R2: a control write while locked leaves control untouched
  p_locked_ctrl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked && widx == W_CTRL) |=> $stable(ctrl))
    else $error("p_locked_ctrl_r2");

  // R2: test registers unchanged while locked
  p_locked_test_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && locked) |=> ($stable(test_en) && $stable(test_out) && $stable(load_val)))
    else $error("p_locked_test_r2");
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [CNT_W-1:0] load_val,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_data,
  input  logic             clr_wr,
  output logic [CNT_W-1:0] cnt,
  output logic             raw_irq,
  output logic             rst_flag
);
  logic at_zero;
  logic expire;

  assign at_zero = (cnt == '0);
  // a bus reload or clear in the same cycle pre-empts an expiry
  assign expire  = ctrl.int_en && at_zero && !load_wr && !clr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= LOAD_RST;
    else if (load_wr)         cnt <= load_data;
    else if (clr_wr)          cnt <= load_val;
    else if (ctrl.int_en)     cnt <= at_zero ? load_val : cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       raw_irq <= 1'b0;
    else if (clr_wr)  raw_irq <= 1'b0;
    else if (expire)  raw_irq <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 rst_flag <= 1'b0;
    else if (expire && raw_irq && ctrl.rst_en)  rst_flag <= 1'b1;
  end

  // R3: a start-value write loads the counter on the next cycle
  p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt == $past(load_data)))
    else $error("p_reload_r3");

  // R4: counter frozen while disabled and untouched by the bus
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.int_en && !load_wr && !clr_wr) |=> $stable(cnt))
    else $error("p_hold_r4");

  // R6: reset request is sticky
  p_rst_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_flag |=> rst_flag)
    else $error("p_rst_sticky_r6");

  // R7: a clear drops the pending interrupt
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> !raw_irq)
    else $error("p_clear_r7");
endmodule

// File: rtl/kwdt_outmux.sv
module kwdt_outmux
  import kwdt_pkg::*;
(
  input  logic       test_en,
  input  logic [1:0] test_out,
  input  logic       raw_irq,
  input  ctrl_t      ctrl,
  input  logic       rst_flag,
  output logic       irq_o,
  output logic       rst_o
);
  always_comb begin
    if (test_en) begin
      irq_o = test_out[0];
      rst_o = test_out[1];
    end else begin
      irq_o = raw_irq & ctrl.int_en;
      rst_o = rst_flag;
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] LOAD_RST = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_enable,
  input  logic        bus_write,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdog_irq,
  output logic        wdog_rst
);
  logic             wr_en, rd_en;
  logic [CNT_W-1:0] load_val, cnt;
  ctrl_t            ctrl;
  logic             test_en;
  logic [1:0]       test_out;
  logic             load_wr, clr_wr;
  logic             raw_irq, rst_flag;

  assign wr_en = bus_sel && bus_enable && bus_write;
  assign rd_en = bus_sel && !bus_write;

  kwdt_regs #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .cnt(cnt), .raw_irq(raw_irq),
    .load_val(load_val), .ctrl(ctrl), .test_en(test_en), .test_out(test_out),
    .load_wr(load_wr), .clr_wr(clr_wr), .rdata(bus_rdata)
  );

  kwdt_counter #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .load_val(load_val),
    .load_wr(load_wr), .load_data(bus_wdata[CNT_W-1:0]), .clr_wr(clr_wr),
    .cnt(cnt), .raw_irq(raw_irq), .rst_flag(rst_flag)
  );

  kwdt_outmux u_mux (
    .test_en(test_en), .test_out(test_out), .raw_irq(raw_irq), .ctrl(ctrl),
    .rst_flag(rst_flag), .irq_o(wdog_irq), .rst_o(wdog_rst)
  );

  // R6: a reset request outside test mode needs a pending interrupt
  p_rst_needs_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_flag)) |-> $past(raw_irq))
    else $error("p_rst_needs_irq_r6");
endmodule

// File: tb/kwdt_top_test.sv
module kwdt_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_enable = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_irq, wdog_rst;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] KEY = 32'h1ACC_E551;

  always #5 clk = ~clk;

  kwdt_top uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_enable(bus_enable),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wdog_irq(wdog_irq), .wdog_rst(wdog_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // returns half a cycle after the committing edge
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_enable = 0;
    @(negedge clk); bus_enable = 1;
    @(negedge clk); bus_sel = 0; bus_enable = 0; bus_write = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_write = 0; bus_addr = a; bus_enable = 0;
    @(negedge clk); bus_enable = 1;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0; bus_enable = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    check("R5 irq after reset", {31'h0, wdog_irq}, 32'h0);
    check("R6 rst after reset", {31'h0, wdog_rst}, 32'h0);
    bus_rd(12'hC00, d); check("R1 locked after reset", d, 32'h1);
    bus_rd(12'h000, d); check("R3 start value after reset", d, 32'hFFFF_FFFF);
    bus_rd(12'h004, d); check("R3 counter after reset", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_wr(12'h000, 32'h0000_1234);
    bus_rd(12'h000, d); check("R2 locked start write ignored", d, 32'hFFFF_FFFF);
    bus_wr(12'h008, 32'h3);
    bus_rd(12'h008, d); check("R2 locked control write ignored", d, 32'h0);
    bus_wr(12'hF00, 32'h1);
    bus_rd(12'hF00, d); check("R2 locked test write ignored", d, 32'h0);
    bus_wr(12'hC00, KEY);
    bus_rd(12'hC00, d); check("R1 unlocked by key", d, 32'h0);
    bus_wr(12'h000, 32'h0000_0077);
    bus_rd(12'h000, d); check("R3 start value write", d, 32'h77);
    bus_rd(12'h004, d); check("R3 counter loaded at once", d, 32'h77);
    bus_wr(12'hC00, 32'h1ACC_E550);
    bus_rd(12'hC00, d); check("R1 relocked by wrong value", d, 32'h1);
    bus_wr(12'h008, 32'h1);
    bus_rd(12'h008, d); check("R2 control ignored after relock", d, 32'h0);
  endtask

  task automatic t_expiry_and_reset();
    bus_wr(12'hC00, KEY);
    bus_wr(12'h000, 32'd5);
    bus_wr(12'h008, 32'h3);
    repeat (5) @(posedge clk); @(negedge clk);
    check("R5 irq low after L edges", {31'h0, wdog_irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R5 irq high after L+1 edges", {31'h0, wdog_irq}, 32'h1);
    repeat (5) @(posedge clk); @(negedge clk);
    check("R6 rst low before second expiry", {31'h0, wdog_rst}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R6 rst high at second expiry", {31'h0, wdog_rst}, 32'h1);
    bus_wr(12'h00C, 32'h0);
    check("R7 clear drops irq", {31'h0, wdog_irq}, 32'h0);
    check("R6 rst sticky after clear", {31'h0, wdog_rst}, 32'h1);
    repeat (10) @(negedge clk);
    check("R6 rst still held", {31'h0, wdog_rst}, 32'h1);
  endtask

  task automatic t_clear_reload();
    logic [31:0] d, d2;
    bus_wr(12'hC00, KEY);
    bus_wr(12'h000, 32'd20);
    bus_wr(12'h008, 32'h3);
    repeat (21) @(posedge clk); @(negedge clk);
    check("R5 irq with L=20", {31'h0, wdog_irq}, 32'h1);
    bus_wr(12'h00C, 32'hDEAD_BEEF);
    check("R7 clear with any data", {31'h0, wdog_irq}, 32'h0);
    repeat (20) @(posedge clk); @(negedge clk);
    check("R7 counter reloaded, no early irq", {31'h0, wdog_irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R7 irq L+1 edges after clear", {31'h0, wdog_irq}, 32'h1);
    check("R6 no rst when cleared in time", {31'h0, wdog_rst}, 32'h0);
    bus_wr(12'h008, 32'h0);
    check("R8 output masked", {31'h0, wdog_irq}, 32'h0);
    bus_rd(12'h010, d); check("R8 raw status", d, 32'h1);
    bus_rd(12'h014, d); check("R8 masked status", d, 32'h0);
    bus_rd(12'h004, d);
    repeat (10) @(negedge clk);
    bus_rd(12'h004, d2); check("R4 counter holds when disabled", d2, d);
    bus_wr(12'h008, 32'h1);
    bus_rd(12'h014, d); check("R8 masked status enabled", d, 32'h1);
  endtask

  task automatic t_test_mode();
    bus_wr(12'hC00, KEY);
    bus_wr(12'h008, 32'h0);
    bus_wr(12'hF04, 32'h2);
    check("R9 test reg alone no effect", {30'h0, wdog_rst, wdog_irq}, 32'h0);
    bus_wr(12'hF00, 32'h1);
    check("R9 test drives rst only", {30'h0, wdog_rst, wdog_irq}, 32'h2);
    bus_wr(12'hF04, 32'h1);
    check("R9 test drives irq only", {30'h0, wdog_rst, wdog_irq}, 32'h1);
    bus_wr(12'hF00, 32'h0);
    check("R9 normal outputs back", {30'h0, wdog_rst, wdog_irq}, 32'h0);
  endtask

  task automatic t_id_reserved();
    logic [31:0] d;
    logic [7:0] exp_id [8] = '{8'h4B, 8'h57, 8'h10, 8'h00, 8'hA5, 8'h3C, 8'h96, 8'h0F};
    for (int i = 0; i < 8; i++) begin
      bus_rd(12'hFE0 + 12'(i * 4), d);
      check("R10 id byte", d, {24'h0, exp_id[i]});
    end
    bus_wr(12'hC00, KEY);
    bus_wr(12'h018, 32'hFFFF_FFFF);
    bus_rd(12'h018, d); check("R10 reserved reads zero", d, 32'h0);
    bus_wr(12'h400, 32'h5);
    bus_rd(12'h400, d); check("R10 reserved write ignored", d, 32'h0);
    bus_rd(12'h008, d); check("R10 control untouched by reserved", d, 32'h0);
  endtask

  initial begin
    apply_reset();
    t_reset_state();
    t_lock();
    apply_reset();
    t_expiry_and_reset();
    apply_reset();
    check("R6 rst cleared by block reset", {31'h0, wdog_rst}, 32'h0);
    t_clear_reload();
    apply_reset();
    t_test_mode();
    apply_reset();
    t_id_reserved();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule